// File: doc/BRIEF.md
# Tick-Rate Trimmer

This block sits in a tick-enable path, between a source that emits single-cycle enable pulses and the prescaler that counts them. It trims the average tick rate by a small fraction to correct a source oscillator that runs fast or slow. It generates no clock. Its output is another single-cycle tick-enable stream in the same clock domain.

Software writes a non-zero magnitude `cfg_value`, a non-zero exponent `cfg_exp` and a direction bit `cfg_add` in one write cycle. The block derives a correction period N = ceil(256 / value) · 2^exp. In slow-down mode it lets N ticks through and then drops the next one, so the rate becomes f0 · (1 − 1/(N+1)). In speed-up mode it adds one extra tick in the idle cycle after every N-th input tick, so the rate becomes f0 · (1 + 1/N). A magnitude of zero or an exponent of zero turns the correction off, and the input then passes through unchanged.

Top module: `tick_trim_top`

## Requirements
- R1: After reset, and with no configuration written, the block applies no correction: `tick_out` equals `tick_in` in every cycle.
- R2: A configuration written with `cfg_value` = 0 turns the correction off, whatever the exponent and direction: `tick_out` equals `tick_in` from the next cycle on.
- R3: A configuration written with `cfg_exp` = 0 is invalid and turns the correction off: `tick_out` equals `tick_in` from the next cycle on.
- R4: For a valid configuration the correction period is N = ceil(256 / `cfg_value`) shifted left by `cfg_exp`. The rounding is upward (value 3 gives 86, not 85). The largest period is 256 · 2^7.
- R5: With `cfg_add` = 0 (slow-down), counting input ticks from the last configuration write, ticks 1 to N pass and tick N+1 is dropped, and this pattern repeats every N+1 input ticks. Cycles without an input tick give no output tick.
- R6: With `cfg_add` = 1 (speed-up), every input tick passes. In the cycle that follows every N-th input tick since the last write, one extra output tick is emitted.
- R7: The cycle with `cfg_we` high passes `tick_in` to `tick_out` unchanged. That cycle also restarts the tick count at zero and discards a pending extra tick. The new configuration takes effect from the next cycle.
- R8: Speed-up mode requires input ticks to be separated by at least one idle cycle. The extra tick in R6 falls into that idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the tick stream and the configuration write |
| rst_n | input | 1 | Active-low synchronous reset; clears the configuration to correction-off |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_value | input | 8 | Trim magnitude; 0 turns the correction off |
| cfg_exp | input | 3 | Period exponent; 0 is invalid and turns the correction off |
| cfg_add | input | 1 | Direction: 0 drops ticks (slower), 1 adds ticks (faster) |
| tick_in | input | 1 | Incoming tick-enable pulse |
| tick_out | output | 1 | Trimmed tick-enable pulse |

## Verification
The trimmer is driven with sparse random tick streams under both directions. It uses a short period (value 255, exponent 1, N = 4), so that many drop or insert events occur, and a long period (value 1, N = 512), which exercises the full counter. A value of 3 separates upward rounding of the quotient from truncation: N is 172 with upward rounding and 170 with truncation. The value-zero and exponent-zero configurations must match plain pass-through bit for bit. A write issued while an extra tick is pending shows whether the write cycle passes its input unchanged and discards the pending tick. Random configurations with exponents of 1 to 3 then check the drop and insert positions against a model that computes them by modular arithmetic on the tick count.

// File: rtl/tick_trim_pkg.sv
package tick_trim_pkg;

  typedef enum logic [1:0] {
    TRIM_OFF  = 2'd0,
    TRIM_SLOW = 2'd1,
    TRIM_FAST = 2'd2
  } trim_mode_e;

  function automatic trim_mode_e decode_mode(input logic value_nz,
                                             input logic exp_nz,
                                             input logic add);
    if (!value_nz || !exp_nz) return TRIM_OFF;
    return add ? TRIM_FAST : TRIM_SLOW;
  endfunction

endpackage

// File: rtl/tick_trim_cfg.sv
module tick_trim_cfg
  import tick_trim_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int EXP_W = 3,
  parameter int CNT_W = VAL_W + (1 << EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VAL_W-1:0] value,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             add,
  output trim_mode_e       mode,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] FULL_SCALE = CNT_W'(1) << VAL_W;

  // ceil(2^VAL_W / v), widened to the counter width
  function automatic logic [CNT_W-1:0] ceil_quot(input logic [VAL_W-1:0] v);
    logic [CNT_W-1:0] den;
    den = CNT_W'(v);
    if (den == '0) return '0;
    return (FULL_SCALE + den - CNT_W'(1)) / den;
  endfunction

  function automatic logic [CNT_W-1:0] period_of(input logic [VAL_W-1:0] v,
                                                 input logic [EXP_W-1:0] e);
    return ceil_quot(v) << e;
  endfunction

  logic [CNT_W-1:0] next_period;
  trim_mode_e       next_mode;

  always_comb begin
    next_period = period_of(value, exp_sel);
    next_mode   = decode_mode(value != '0, exp_sel != '0, add);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= TRIM_OFF;
      period <= '0;
    end else if (we) begin
      mode   <= next_mode;
      period <= next_period;
    end
  end

  // R2: a zero magnitude always lands in the off state
  a_r2_zero_value_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && value == '0) |=> mode == TRIM_OFF);

  // R3: a zero exponent always lands in the off state
  a_r3_zero_exp_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && exp_sel == '0) |=> mode == TRIM_OFF);

  // R4: an active mode always carries a usable period
  a_r4_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != TRIM_OFF) |-> (period != '0));

endmodule

// File: rtl/tick_trim_core.sv
module tick_trim_core
  import tick_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  trim_mode_e       mode,
  input  logic [CNT_W-1:0] period,
  input  logic             tick_in,
  output logic             tick_out
);

  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             running;
  logic             at_end;
  logic             wrap;
  logic             swallow;

  always_comb begin
    running  = (mode != TRIM_OFF);
    at_end   = (mode == TRIM_SLOW) ? (cnt == period) : (cnt == period - CNT_W'(1));
    wrap     = running && tick_in && at_end && !cfg_we;
    swallow  = wrap && (mode == TRIM_SLOW);
    tick_out = cfg_we ? tick_in : ((tick_in && !swallow) || pend);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (cfg_we) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (running) begin
      pend <= wrap && (mode == TRIM_FAST);
      if (tick_in) cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end else begin
      cnt  <= '0;
      pend <= 1'b0;
    end
  end

  // R1: with no correction active, the stream passes untouched
  a_r1_off_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIM_OFF) |-> (tick_out == tick_in));

  // R5: a dropped tick only ever replaces a real input tick
  a_r5_swallow_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    swallow |-> (tick_in && !tick_out));

  // R5: the tick count never passes the programmed period
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= period));

  // R6: extra ticks exist only in speed-up mode
  a_r6_pend_fast_only: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (mode == TRIM_FAST));

  // R7: a write restarts the count and discards a pending extra tick
  a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt == '0 && !pend));

  // R8: the extra tick lands in the idle cycle after an input tick
  a_r8_extra_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(tick_in));

endmodule

// File: rtl/tick_trim_top.sv
module tick_trim_top
  import tick_trim_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [VAL_W-1:0] cfg_value,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic             cfg_add,
  input  logic             tick_in,
  output logic             tick_out
);

  localparam int CNT_W = VAL_W + (1 << EXP_W);

  trim_mode_e       mode;
  logic [CNT_W-1:0] period;

  tick_trim_cfg #(
    .VAL_W(VAL_W),
    .EXP_W(EXP_W),
    .CNT_W(CNT_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .value   (cfg_value),
    .exp_sel (cfg_exp),
    .add     (cfg_add),
    .mode    (mode),
    .period  (period)
  );

  tick_trim_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .mode     (mode),
    .period   (period),
    .tick_in  (tick_in),
    .tick_out (tick_out)
  );

endmodule

// File: tb/tb_tick_trim_top.sv
`timescale 1ns/1ps
module tb_tick_trim_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_value = '0;
  logic [2:0] cfg_exp = '0;
  logic       cfg_add = 1'b0;
  logic       tick_in = 1'b0;
  logic       tick_out;

  int checks = 0;
  int fails = 0;

  // model state: 0 off, 1 slow, 2 fast
  int m_mode = 0;
  int m_n = 0;
  int seen = 0;
  bit pend = 0;
  bit prev_tick = 0;

  always #10 clk = ~clk;

  tick_trim_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_value(cfg_value),
    .cfg_exp(cfg_exp), .cfg_add(cfg_add), .tick_in(tick_in), .tick_out(tick_out)
  );

  // smallest q with q*v >= 256, then scaled by 2^e
  function automatic int bench_period(input int v, input int e);
    int q = 1;
    while (q * v < 256) q++;
    return q * (1 << e);
  endfunction

  task automatic step(input bit we, input int v, input int e, input bit a,
                      input bit t, input string req);
    bit expv;
    bit newp;
    @(negedge clk);
    cfg_we = we; cfg_value = 8'(v); cfg_exp = 3'(e); cfg_add = a; tick_in = t;
    #5;
    if (we || m_mode == 0) expv = t;
    else if (m_mode == 1) expv = t && ((seen % (m_n + 1)) != m_n);
    else expv = t || pend;
    checks++;
    if (tick_out !== expv) begin
      fails++;
      $display("FAIL %s: tick_out=%0b expected=%0b (mode=%0d N=%0d seen=%0d)",
               req, tick_out, expv, m_mode, m_n, seen);
    end
    if (we) begin
      m_mode = (v == 0 || e == 0) ? 0 : (a ? 2 : 1);
      m_n = (m_mode == 0) ? 0 : bench_period(v, e);
      seen = 0; pend = 0;
    end else if (m_mode == 1) begin
      if (t) seen++;
    end else if (m_mode == 2) begin
      newp = t && (((seen + 1) % m_n) == 0);
      if (t) seen++;
      pend = newp;
    end
    prev_tick = t;
  endtask

  function automatic bit rand_tick();
    return !prev_tick && ($urandom % 3 != 0);
  endfunction

  task automatic run_cfg(input int v, input int e, input bit a, input int cycles,
                         input string req);
    step(1'b1, v, e, a, rand_tick(), "R7");
    for (int i = 0; i < cycles; i++)
      step(1'b0, v, e, a, rand_tick(), req);
  endtask

  function automatic int cycles_for(input int v, input int e);
    int n = bench_period(v, e);
    int c = 3 * 2 * (n + 1) + 40;
    return (c > 6000) ? 6000 : c;
  endfunction

  initial begin
    int unsigned s;
    s = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no configuration yet
    for (int i = 0; i < 40; i++) step(1'b0, 0, 0, 1'b0, rand_tick(), "R1");
    // R2 / R3: correction off
    run_cfg(0, 3, 1'b0, 60, "R2");
    run_cfg(0, 5, 1'b1, 60, "R2");
    run_cfg(5, 0, 1'b1, 60, "R3");
    run_cfg(5, 0, 1'b0, 60, "R3");
    // R4 / R5 / R6 directed periods
    run_cfg(255, 1, 1'b0, 200, "R5");
    run_cfg(255, 1, 1'b1, 200, "R6");
    run_cfg(3, 1, 1'b0, cycles_for(3, 1), "R4");
    run_cfg(3, 1, 1'b1, cycles_for(3, 1), "R4");
    run_cfg(1, 1, 1'b0, cycles_for(1, 1), "R5");
    run_cfg(1, 1, 1'b1, cycles_for(1, 1), "R6");
    run_cfg(128, 2, 1'b1, 200, "R8");
    // R7: write arriving while an extra tick is pending
    step(1'b1, 255, 1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 200 && !pend; i++) step(1'b0, 255, 1, 1'b1, rand_tick(), "R6");
    step(1'b1, 255, 2, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 100; i++) step(1'b0, 255, 2, 1'b1, rand_tick(), "R7");
    // random configurations
    for (int k = 0; k < 14; k++) begin
      int v = 1 + ($urandom % 255);
      int e = 1 + ($urandom % 3);
      bit a = 1'($urandom % 2);
      run_cfg(v, e, a, cycles_for(v, e), a ? "R6" : "R5");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule